// File: doc/BRIEF.md
# Byte-Word Packer for a Serial Bus Engine

This block sits between a 32-bit word interface on the register side and a byte-serial bus engine. On the transmit path, software pushes 32-bit words into a small TX word queue. A transfer is started with a byte length. The block then hands bytes to the engine, least significant lane first, and stops at exactly that length. Lanes of the final word that lie past the length are thrown away.

On the receive path, bytes from the engine are gathered four to a word, the first byte in the lowest lane. When the engine marks the last byte of a transfer, any bytes still pending are flushed as one partial word, with zero in the empty lanes. That word carries a flag that is visible while it sits at the head of the RX queue.

Both paths drive level-based watermark interrupts. A watermark of zero switches the interrupt off. Reading an empty RX queue and writing a full TX queue are both reported.

Top module: `byte_word_packer`

## Requirements
- R1: Each TX word is sent as bytes in little-endian lane order: bits 7:0 first, then 15:8, 23:16 and 31:24.
- R2: After `tx_start_i` with length N, exactly N bytes are sent, and `tx_byte_last_o` is high only on the Nth byte. Unused upper lanes of the final word are discarded, so the next transfer begins at lane 0 of the next queued word.
- R3: `tx_wm_irq_o` is high when `tx_wm_i` is non-zero and the TX queue holds no more than `tx_wm_i` words.
- R4: With `tx_wm_i` equal to zero, `tx_wm_irq_o` stays low at every queue level.
- R5: A TX word write while the queue holds DEPTH words is dropped, and `tx_ovf_o` is high for the one cycle after that write.
- R6: Four consecutive RX bytes form one word, with the first byte in bits 7:0 and each later byte one lane higher.
- R7: An RX byte marked last that completes fewer than four lanes flushes a word whose unfilled lanes are zero. `rx_last_o` is high while that word is at the head of the RX queue.
- R8: `rx_last_o` is low for a word holding four bytes, including when the fourth byte is marked last.
- R9: `rx_words_o` rises by one on the clock edge that takes a word-completing byte, and falls by one on the edge that takes `rx_rd_i`.
- R10: `rx_wm_irq_o` is high when `rx_wm_i` is non-zero and `rx_words_o` is at least `rx_wm_i`.
- R11: While the RX queue is empty, `rx_rdata_o` reads zero. A read in that state leaves `rx_words_o` at zero and makes `rx_udf_o` high for the next cycle.
- R12: After reset both queues are empty, no byte is offered, and all flags and interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Push `tx_wdata_i` into the TX queue |
| tx_wdata_i | input | 32 | TX word |
| tx_wm_i | input | CNT_W | TX watermark; 0 disables |
| tx_wm_irq_o | output | 1 | TX level at or below watermark |
| tx_ovf_o | output | 1 | One-cycle pulse after a dropped TX write |
| tx_start_i | input | 1 | Begin a TX transfer of `tx_len_i` bytes |
| tx_len_i | input | LEN_W | TX transfer length in bytes |
| tx_byte_o | output | 8 | Byte to engine |
| tx_byte_valid_o | output | 1 | `tx_byte_o` valid |
| tx_byte_last_o | output | 1 | Final byte of the transfer |
| tx_byte_ready_i | input | 1 | Engine takes the byte |
| rx_byte_i | input | 8 | Byte from engine |
| rx_byte_valid_i | input | 1 | `rx_byte_i` valid |
| rx_byte_last_i | input | 1 | Final byte of the RX transfer |
| rx_rd_i | input | 1 | Pop the head RX word |
| rx_rdata_o | output | 32 | Head RX word; zero when empty |
| rx_last_o | output | 1 | Head word is a flushed partial word |
| rx_words_o | output | CNT_W | Words in the RX queue |
| rx_wm_i | input | CNT_W | RX watermark; 0 disables |
| rx_wm_irq_o | output | 1 | RX level at or above watermark |
| rx_udf_o | output | 1 | One-cycle pulse after a read of an empty queue |

## Verification
Watermark interrupts, `rx_rdata_o` and `rx_last_o` follow the queue levels combinationally. The bench therefore checks them at the falling edge after the edge that changed the level. `rx_words_o` and the overflow and underflow pulses are registered on the edge that samples the stimulus, and each one is checked at the very next falling edge, before a second edge could clear it. The first TX byte appears one cycle after the edge that takes `tx_start_i`, because the word is loaded from the queue on that cycle. The bench collects bytes at every falling edge with ready held high, then watches several more cycles to confirm that nothing follows the last byte.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = WORD_W / BYTE_W;
  localparam int unsigned LANE_W = $clog2(LANES);
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/bwp_fifo.sv
module bwp_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] level_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] level_q;
  logic             full, empty, do_push, do_pop;

  assign full    = (level_q == CNT_W'(DEPTH));
  assign empty   = (level_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + CNT_W'(1);
        2'b01:   level_q <= level_q - CNT_W'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CNT_W'(DEPTH)); // R5
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full && !pop_i) |=> (level_q == $past(level_q) + CNT_W'(1))); // R9
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty && !push_i) |=> (level_q == $past(level_q) - CNT_W'(1))); // R9
endmodule

// File: rtl/bwp_tx_unpack.sv
module bwp_tx_unpack
  import bwp_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  word_t            word_i,
  input  logic             word_avail_i,
  output logic             pop_o,
  output byte_t            byte_o,
  output logic             valid_o,
  output logic             last_o,
  input  logic             ready_i
);
  word_t             word_q;
  logic [LANE_W-1:0] lane_q;
  logic [LEN_W-1:0]  remain_q;
  logic              have_q;

  assign pop_o = !have_q && (remain_q != '0) && word_avail_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= '0;
      lane_q   <= '0;
      remain_q <= '0;
      have_q   <= 1'b0;
    end else if (start_i) begin
      remain_q <= len_i;
      have_q   <= 1'b0;
    end else if (pop_o) begin
      word_q <= word_i;
      lane_q <= '0;
      have_q <= 1'b1;
    end else if (have_q && ready_i) begin
      remain_q <= remain_q - LEN_W'(1);
      lane_q   <= lane_q + LANE_W'(1);
      // drop the word after its top lane or at the length bound
      if (lane_q == LANE_W'(LANES - 1) || remain_q == LEN_W'(1)) have_q <= 1'b0;
    end
  end

  assign byte_o  = word_q[{lane_q, 3'b000} +: BYTE_W];
  assign valid_o = have_q;
  assign last_o  = have_q && (remain_q == LEN_W'(1));

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !start_i) |=> (valid_o && $stable(byte_o))); // R1
  AST_TX_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && ready_i) |=> !valid_o); // R2
endmodule

// File: rtl/bwp_rx_pack.sv
module bwp_rx_pack
  import bwp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  byte_t byte_i,
  input  logic  valid_i,
  input  logic  last_i,
  output logic  push_o,
  output word_t word_o,
  output logic  partial_o
);
  word_t             acc_q, merged;
  logic [LANE_W-1:0] lane_q;
  logic              top_lane;

  assign top_lane  = (lane_q == LANE_W'(LANES - 1));
  assign merged    = acc_q | (word_t'(byte_i) << {lane_q, 3'b000});
  assign push_o    = valid_i && (top_lane || last_i);
  assign word_o    = merged;
  assign partial_o = last_i && !top_lane;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (valid_i) begin
      if (push_o) begin
        acc_q  <= '0;
        lane_q <= '0;
      end else begin
        acc_q  <= merged;
        lane_q <= lane_q + LANE_W'(1);
      end
    end
  end

  AST_RX_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && partial_o) |-> (word_o[WORD_W-1 -: BYTE_W] == '0)); // R7
  AST_RX_FRESH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> (acc_q == '0)); // R6
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
  import bwp_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LEN_W = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_wr_i,
  input  logic [31:0]      tx_wdata_i,
  input  logic [CNT_W-1:0] tx_wm_i,
  output logic             tx_wm_irq_o,
  output logic             tx_ovf_o,
  input  logic             tx_start_i,
  input  logic [LEN_W-1:0] tx_len_i,
  output logic [7:0]       tx_byte_o,
  output logic             tx_byte_valid_o,
  output logic             tx_byte_last_o,
  input  logic             tx_byte_ready_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             rx_byte_valid_i,
  input  logic             rx_byte_last_i,
  input  logic             rx_rd_i,
  output logic [31:0]      rx_rdata_o,
  output logic             rx_last_o,
  output logic [CNT_W-1:0] rx_words_o,
  input  logic [CNT_W-1:0] rx_wm_i,
  output logic             rx_wm_irq_o,
  output logic             rx_udf_o
);
  word_t            tx_head;
  logic [CNT_W-1:0] tx_level, rx_level;
  logic             tx_pop, tx_full, tx_empty, rx_empty;
  logic             rx_push, rx_partial;
  word_t            rx_word;
  logic [WORD_W:0]  rx_head;
  logic             ovf_q, udf_q;

  bwp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_wr_i), .data_i(tx_wdata_i),
    .pop_i(tx_pop), .data_o(tx_head), .level_o(tx_level)
  );

  bwp_tx_unpack #(.LEN_W(LEN_W)) u_unpack (
    .clk_i, .rst_ni,
    .start_i(tx_start_i), .len_i(tx_len_i),
    .word_i(tx_head), .word_avail_i(!tx_empty), .pop_o(tx_pop),
    .byte_o(tx_byte_o), .valid_o(tx_byte_valid_o), .last_o(tx_byte_last_o),
    .ready_i(tx_byte_ready_i)
  );

  bwp_rx_pack u_pack (
    .clk_i, .rst_ni,
    .byte_i(rx_byte_i), .valid_i(rx_byte_valid_i), .last_i(rx_byte_last_i),
    .push_o(rx_push), .word_o(rx_word), .partial_o(rx_partial)
  );

  // entry = {partial flag, word}
  bwp_fifo #(.WIDTH(WORD_W + 1), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .data_i({rx_partial, rx_word}),
    .pop_i(rx_rd_i), .data_o(rx_head), .level_o(rx_level)
  );

  assign tx_full  = (tx_level == CNT_W'(DEPTH));
  assign tx_empty = (tx_level == '0);
  assign rx_empty = (rx_level == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= tx_wr_i && tx_full;
      udf_q <= rx_rd_i && rx_empty;
    end
  end

  assign tx_ovf_o    = ovf_q;
  assign rx_udf_o    = udf_q;
  assign tx_wm_irq_o = (tx_wm_i != '0) && (tx_level <= tx_wm_i);
  assign rx_wm_irq_o = (rx_wm_i != '0) && (rx_level >= rx_wm_i);
  assign rx_words_o  = rx_level;
  assign rx_rdata_o  = rx_empty ? '0 : rx_head[WORD_W-1:0];
  assign rx_last_o   = !rx_empty && rx_head[WORD_W];

  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |-> $past(tx_level == CNT_W'(DEPTH))); // R5
  AST_UDF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_udf_o |-> ($past(rx_rdata_o) == '0)); // R11
endmodule

// File: tb/byte_word_packer_bench.sv
module byte_word_packer_bench;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned LEN_W = 16;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic             tx_wr_i = 0;
  logic [31:0]      tx_wdata_i = '0;
  logic [CNT_W-1:0] tx_wm_i = '0;
  logic             tx_wm_irq_o, tx_ovf_o;
  logic             tx_start_i = 0;
  logic [LEN_W-1:0] tx_len_i = '0;
  logic [7:0]       tx_byte_o;
  logic             tx_byte_valid_o, tx_byte_last_o;
  logic             tx_byte_ready_i = 1'b1;
  logic [7:0]       rx_byte_i = '0;
  logic             rx_byte_valid_i = 0, rx_byte_last_i = 0, rx_rd_i = 0;
  logic [31:0]      rx_rdata_o;
  logic             rx_last_o, rx_wm_irq_o, rx_udf_o;
  logic [CNT_W-1:0] rx_words_o;
  logic [CNT_W-1:0] rx_wm_i = '0;

  byte_word_packer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_byte_word_packer (
    .clk_i(clk), .rst_ni,
    .tx_wr_i, .tx_wdata_i, .tx_wm_i, .tx_wm_irq_o, .tx_ovf_o,
    .tx_start_i, .tx_len_i, .tx_byte_o, .tx_byte_valid_o, .tx_byte_last_o,
    .tx_byte_ready_i,
    .rx_byte_i, .rx_byte_valid_i, .rx_byte_last_i,
    .rx_rd_i, .rx_rdata_o, .rx_last_o, .rx_words_o, .rx_wm_i, .rx_wm_irq_o,
    .rx_udf_o
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_word(logic [31:0] w);
    @(negedge clk); tx_wr_i = 1; tx_wdata_i = w;
    @(negedge clk); tx_wr_i = 0;
  endtask

  task automatic start_tx(int len);
    @(negedge clk); tx_start_i = 1; tx_len_i = LEN_W'(len);
    @(negedge clk); tx_start_i = 0;
  endtask

  task automatic send_byte(logic [7:0] b, logic last);
    @(negedge clk); rx_byte_valid_i = 1; rx_byte_i = b; rx_byte_last_i = last;
    @(negedge clk); rx_byte_valid_i = 0; rx_byte_last_i = 0;
  endtask

  task automatic rd_word();
    @(negedge clk); rx_rd_i = 1;
    @(negedge clk); rx_rd_i = 0;
  endtask

  // collect bytes with ready high; expect seq bytes, last only on final
  task automatic collect(string req, logic [7:0] exp_b [], int n);
    int got = 0;
    for (int c = 0; c < 60 && got < n; c++) begin
      @(negedge clk);
      if (tx_byte_valid_o) begin
        check(req, {24'd0, tx_byte_o}, {24'd0, exp_b[got]});
        check("R2 last", {31'd0, tx_byte_last_o}, {31'd0, got == n - 1});
        got++;
      end
    end
    check("R2 count", got, n);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (tx_byte_valid_o) check("R2 extra byte", 1, 0);
    end
  endtask

  // {n_bytes[8], first byte[8], expected word[32], expected last flag[1]}
  localparam logic [48:0] RX_TAB [5] = '{
    {8'd4, 8'h11, 32'h14131211, 1'b0},
    {8'd3, 8'hA0, 32'h00A2A1A0, 1'b1},
    {8'd2, 8'h55, 32'h00005655, 1'b1},
    {8'd1, 8'hFF, 32'h000000FF, 1'b1},
    {8'd4, 8'hFC, 32'hFFFEFDFC, 1'b0}
  };

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] eb [];
    logic [31:0] ws [4];
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 valid", {31'd0, tx_byte_valid_o}, 0);
    check("R12 words", {29'd0, rx_words_o}, 0);
    check("R12 rdata", rx_rdata_o, 0);
    check("R12 flags", {28'd0, rx_last_o, tx_ovf_o, rx_udf_o, tx_wm_irq_o}, 0);

    // RX table: R6 packing, R7 partial flush, R8 full word flag, R9 count
    for (int i = 0; i < 5; i++) begin
      logic [48:0] e;
      int nb;
      e = RX_TAB[i];
      nb = int'(e[48:41]);
      for (int k = 0; k < nb; k++) send_byte(e[40:33] + 8'(k), k == nb - 1);
      check("R9 count up", {29'd0, rx_words_o}, 1);
      check(e[0] ? "R7 word" : "R6 word", rx_rdata_o, e[32:1]);
      check(e[0] ? "R7 flag" : "R8 flag", {31'd0, rx_last_o}, {31'd0, e[0]});
      rd_word();
      check("R9 count down", {29'd0, rx_words_o}, 0);
    end

    // R10 RX watermark
    rx_wm_i = 2;
    for (int k = 0; k < 4; k++) send_byte(8'h20 + 8'(k), 0);
    check("R10 below", {31'd0, rx_wm_irq_o}, 0);
    for (int k = 0; k < 4; k++) send_byte(8'h30 + 8'(k), 0);
    check("R9 two words", {29'd0, rx_words_o}, 2);
    check("R10 reached", {31'd0, rx_wm_irq_o}, 1);
    rx_wm_i = 0;
    @(negedge clk);
    check("R10 disabled", {31'd0, rx_wm_irq_o}, 0);
    check("R6 first", rx_rdata_o, 32'h23222120);
    rd_word();
    check("R6 second", rx_rdata_o, 32'h33323130);
    rd_word();

    // R11 underflow
    check("R11 empty data", rx_rdata_o, 0);
    rd_word();
    check("R11 pulse", {31'd0, rx_udf_o}, 1);
    check("R11 count", {29'd0, rx_words_o}, 0);
    @(negedge clk);
    check("R11 pulse ends", {31'd0, rx_udf_o}, 0);

    // R1/R2 TX unpack with length bound
    wr_word(32'h44332211);
    wr_word(32'h88776655);
    start_tx(6);
    eb = new[6];
    eb = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    collect("R1 byte", eb, 6);
    wr_word(32'hDDCCBBAA);
    start_tx(2);
    eb = new[2];
    eb = '{8'hAA, 8'hBB};
    collect("R2 next word", eb, 2);

    // R3/R4/R5 TX watermark and overflow
    tx_wm_i = 3;
    @(negedge clk);
    check("R3 empty", {31'd0, tx_wm_irq_o}, 1);
    ws = '{32'h03020100, 32'h07060504, 32'h0B0A0908, 32'h0F0E0D0C};
    for (int k = 0; k < 3; k++) wr_word(ws[k]);
    check("R3 at wm", {31'd0, tx_wm_irq_o}, 1);
    wr_word(ws[3]);
    check("R3 above", {31'd0, tx_wm_irq_o}, 0);
    check("R5 no ovf", {31'd0, tx_ovf_o}, 0);
    wr_word(32'hEEEEEEEE);
    check("R5 ovf", {31'd0, tx_ovf_o}, 1);
    start_tx(16);
    eb = new[16];
    for (int k = 0; k < 16; k++) eb[k] = 8'(k);
    collect("R5 dropped", eb, 16);
    check("R3 drained", {31'd0, tx_wm_irq_o}, 1);
    tx_wm_i = 0;
    @(negedge clk);
    check("R4 off", {31'd0, tx_wm_irq_o}, 0);
    wr_word(32'h12345678);
    check("R4 off level1", {31'd0, tx_wm_irq_o}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule